// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block drives the two power switches of a synchronous step-down stage from a fast system clock. A free-running counter divides the clock into fixed switching periods. At the start of each period the high-side switch is requested on. The request ends on the first of three events: the PWM comparator trip input asserts, the switch-node current-sense flag asserts after a blanking window, or the maximum-duty limit is reached. A dead-band stage keeps both switches off for a set number of clocks between any turn-off and the following turn-on. The high-side gate output is active-low because it drives a P-channel switch. The low-side gate output is active-high.

An overcurrent cutoff ends only the present period. The high side is tried again at the next period start, and the sense flag is then sampled anew. A two-bit mode input selects off, force-low or normal operation. The block latches the mode only at the period boundary, and every mode change goes through the same dead-band logic. The block emits a one-clock period-start tick and, at most once per period, a one-clock overcurrent event. With a 100 MHz clock, the defaults of a 200-count period and a 3-count dead band give 500 kHz switching with 30 ns of dead time.

Top module: `buck_gate_ctrl`

## Requirements
- R1: While reset is asserted, and until the first period start after reset is released, hs_gate_n_o is 1, ls_gate_o is 0 and oc_event_o is 0. cyc_start_o is 0 during reset.
- R2: cyc_start_o pulses for exactly one clock every PERIOD clocks. The first pulse is visible PERIOD clocks after reset is released, and the internal phase counter is 0 in the pulse clock ("offset 0").
- R3: The mode encoding is 2'b00 off, 2'b01 force-low, 2'b10 normal and 2'b11 off. mode_i is sampled only in the last clock of a period (offset PERIOD-1) and takes effect from the next period start. Changes at any other time have no effect.
- R4: In normal mode, when the low side was on at the period start, the high side turns on (hs_gate_n_o goes low) at offset DEAD+1.
- R5: The two gates are never on together. After any turn-off, both gates stay off for at least DEAD clocks before either gate turns on.
- R6: If trip_i is sampled high at offset k while the high side is requested, the request ends and the high side is off from offset k+2. In normal mode this gives max(k-2, 0) high-side-on clocks per period, capped by R8.
- R7: oc_sense_i is ignored while the phase is below DEAD+1+BLANK. At or above that phase, while the high side is requested, a sensed high at offset k ends the request like a trip and drives oc_event_o high for one clock at offset k+1. This happens at most once per period.
- R8: The high side is on for at most PERIOD-3*DEAD-2 clocks per period (offsets DEAD+1 to PERIOD-2*DEAD-2). The low side is back on before the period ends.
- R9: In force-low mode the high side stays off and the low side is on. In off mode (00 or 11) both gates are off.
- R10: After an overcurrent cutoff the high side is tried again in the next period, and that period raises its own event if the flag is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Operating mode: 00 off, 01 force-low, 10 normal, 11 off |
| trip_i | input | 1 | PWM comparator trip; ends the high-side on-time |
| oc_sense_i | input | 1 | Switch-node overcurrent flag |
| hs_gate_n_o | output | 1 | High-side gate command, active low |
| ls_gate_o | output | 1 | Low-side gate command, active high |
| cyc_start_o | output | 1 | One-clock pulse at each period start |
| oc_event_o | output | 1 | One-clock pulse when overcurrent ends a period's on-time |

## Verification
Errors in this block's internal state show up at the gate pins within one period:
- A wrong phase count moves both the tick and the high-side turn-on offset.
- A broken request flag changes the number of clocks the high side is on.
- A damaged dead-band counter either shortens the both-off gap below DEAD clocks or makes the gates overlap.

Each of these is measured clock by clock over whole periods. Latching the mode at the wrong time shows as a changed on-count in a period where mode_i was pulsed mid-period. A fault in the blanking or event logic shows as a missing, early or repeated oc_event_o pulse in periods where the sense flag is driven at the edge of the blanking window, late in the on-time, or held high.

// File: rtl/buck_gc_pkg.sv
package buck_gc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_LOW = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_HS   = 2'b01,
    TGT_LS   = 2'b10
  } target_e;

endpackage

// File: rtl/gc_cycle_timer.sv
module gc_cycle_timer #(
  parameter int PERIOD = 200,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          tick_o
);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  assign wrap_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      if (wrap_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

  // R2: the tick marks phase zero and never lasts two clocks
  p_tick_phase_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (cnt_q == '0));
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

endmodule

// File: rtl/gc_on_time.sv
module gc_on_time
  import buck_gc_pkg::*;
#(
  parameter int PERIOD = 200,
  parameter int DEAD   = 3,
  parameter int BLANK  = 8,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic [1:0]    mode_i,
  input  logic          trip_i,
  input  logic          oc_i,
  output target_e       target_o,
  output logic          oc_evt_o,
  output logic          run_o
);

  localparam int ON_LIMIT  = PERIOD - 2 * DEAD - 3;
  localparam int BLANK_END = DEAD + 1 + BLANK;
  localparam logic [CW-1:0] LIMIT_C = CW'(ON_LIMIT);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK_END);

  mode_e mode_q;
  logic  hs_req_q;
  logic  oc_evt_q;
  logic  oc_hit;
  logic  end_now;

  assign oc_hit  = hs_req_q && oc_i && (cnt_i >= BLANK_C);
  assign end_now = hs_req_q && (trip_i || oc_hit || (cnt_i == LIMIT_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_OFF;
      hs_req_q <= 1'b0;
      oc_evt_q <= 1'b0;
    end else begin
      oc_evt_q <= oc_hit;
      if (wrap_i) begin
        mode_q   <= mode_e'(mode_i);
        hs_req_q <= (mode_e'(mode_i) == MODE_RUN);
      end else if (end_now) begin
        hs_req_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_RUN: target_o = hs_req_q ? TGT_HS : TGT_LS;
      MODE_LOW: target_o = TGT_LS;
      default:  target_o = TGT_NONE;
    endcase
  end

  assign oc_evt_o = oc_evt_q;
  assign run_o    = (mode_q == MODE_RUN);

  // R8: no request survives past the duty limit
  p_req_window_r8: assert property (@(posedge clk) disable iff (rst)
    hs_req_q |-> (cnt_i <= LIMIT_C));
  // R3: a request only exists in normal mode
  p_req_mode_r3: assert property (@(posedge clk) disable iff (rst)
    hs_req_q |-> (mode_q == MODE_RUN));
  // R7: one event at most per period
  p_oc_once_r7: assert property (@(posedge clk) disable iff (rst)
    oc_evt_q |=> !oc_evt_q);
  // R7: an event means the request has ended
  p_oc_clears_r7: assert property (@(posedge clk) disable iff (rst)
    oc_evt_q |-> !hs_req_q);

endmodule

// File: rtl/gc_dead_band.sv
module gc_dead_band
  import buck_gc_pkg::*;
#(
  parameter int DEAD = 3,
  localparam int DW = $clog2(DEAD + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  target_e target_i,
  output logic    hs_n_o,
  output logic    ls_o
);

  logic          hs_n_q;
  logic          ls_q;
  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_n_q <= 1'b1;
      ls_q   <= 1'b0;
      dcnt_q <= DW'(DEAD - 1);
    end else if (!hs_n_q && target_i != TGT_HS) begin
      hs_n_q <= 1'b1;
      dcnt_q <= DW'(DEAD - 1);
    end else if (ls_q && target_i != TGT_LS) begin
      ls_q   <= 1'b0;
      dcnt_q <= DW'(DEAD - 1);
    end else if (hs_n_q && !ls_q) begin
      if (dcnt_q != '0)              dcnt_q <= dcnt_q - 1'b1;
      else if (target_i == TGT_HS)   hs_n_q <= 1'b0;
      else if (target_i == TGT_LS)   ls_q   <= 1'b1;
    end
  end

  assign hs_n_o = hs_n_q;
  assign ls_o   = ls_q;

  // Checker: clocks spent with both gates off, saturating at DEAD
  logic [DW-1:0] off_run_q;
  always_ff @(posedge clk) begin
    if (rst)                          off_run_q <= '0;
    else if (!hs_n_q || ls_q)         off_run_q <= '0;
    else if (off_run_q != DW'(DEAD))  off_run_q <= off_run_q + 1'b1;
  end

  // R5: never both on
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(!hs_n_q && ls_q));
  // R5: each turn-on follows at least DEAD off clocks
  p_gap_ls_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> (off_run_q == DW'(DEAD)));
  p_gap_hs_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_n_q) |-> (off_run_q == DW'(DEAD)));

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import buck_gc_pkg::*;
#(
  parameter int PERIOD = 200,
  parameter int DEAD   = 3,
  parameter int BLANK  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       trip_i,
  input  logic       oc_sense_i,
  output logic       hs_gate_n_o,
  output logic       ls_gate_o,
  output logic       cyc_start_o,
  output logic       oc_event_o
);

  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic          wrap;
  target_e       target;
  logic          run;

  gc_cycle_timer #(.PERIOD(PERIOD)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .tick_o (cyc_start_o)
  );

  gc_on_time #(.PERIOD(PERIOD), .DEAD(DEAD), .BLANK(BLANK)) u_on_time (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnt),
    .wrap_i   (wrap),
    .mode_i   (mode_i),
    .trip_i   (trip_i),
    .oc_i     (oc_sense_i),
    .target_o (target),
    .oc_evt_o (oc_event_o),
    .run_o    (run)
  );

  gc_dead_band #(.DEAD(DEAD)) u_dead (
    .clk      (clk),
    .rst      (rst),
    .target_i (target),
    .hs_n_o   (hs_gate_n_o),
    .ls_o     (ls_gate_o)
  );

  // R9: outside normal mode the high side is off after one settling clock
  p_hs_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run)) |-> hs_gate_n_o);
  // R6: the high side is only on while the phase is inside the on window
  p_hs_window_r6: assert property (@(posedge clk) disable iff (rst)
    !hs_gate_n_o |-> (cnt <= CW'(PERIOD - 2 * DEAD - 2)));

endmodule

// File: tb/test_buck_gate_ctrl.sv
module test_buck_gate_ctrl;

  localparam int T_PERIOD = 200;
  localparam int T_DEAD   = 3;
  localparam int T_BLANK  = 8;
  localparam int NV       = 16;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] trip_k;
    logic [7:0] oc_k;
    logic       glitch;
    logic [7:0] exp_hs;
    logic       exp_oc;
    logic [7:0] exp_first;
    logic       exp_ls;
  } vec_t;

  // mode, trip offset, sense offset, mid-period mode pulse, expected
  // high-side-on clocks, events, first on offset, low side at last offset
  localparam vec_t VEC [NV] = '{
    '{2'b01, 8'd255, 8'd255, 1'b0, 8'd0,   1'b0, 8'd255, 1'b1},
    '{2'b10, 8'd255, 8'd255, 1'b1, 8'd189, 1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd50,  8'd255, 1'b0, 8'd48,  1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd3,   8'd255, 1'b0, 8'd1,   1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd1,   8'd255, 1'b0, 8'd0,   1'b0, 8'd255, 1'b1},
    '{2'b10, 8'd255, 8'd5,   1'b0, 8'd189, 1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd255, 8'd12,  1'b0, 8'd10,  1'b1, 8'd4,   1'b1},
    '{2'b10, 8'd255, 8'd11,  1'b0, 8'd189, 1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd60,  8'd100, 1'b0, 8'd58,  1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd190, 8'd255, 1'b0, 8'd188, 1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd255, 8'd195, 1'b0, 8'd189, 1'b0, 8'd4,   1'b1},
    '{2'b10, 8'd255, 8'd191, 1'b0, 8'd189, 1'b1, 8'd4,   1'b1},
    '{2'b00, 8'd255, 8'd255, 1'b0, 8'd0,   1'b0, 8'd255, 1'b0},
    '{2'b11, 8'd255, 8'd255, 1'b0, 8'd0,   1'b0, 8'd255, 1'b0},
    '{2'b01, 8'd255, 8'd255, 1'b0, 8'd0,   1'b0, 8'd255, 1'b1},
    '{2'b10, 8'd12,  8'd12,  1'b0, 8'd10,  1'b1, 8'd4,   1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b01;
  logic       trip_i = 1'b0;
  logic       oc_sense_i = 1'b0;
  logic       hs_gate_n_o, ls_gate_o, cyc_start_o, oc_event_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  buck_gate_ctrl #(.PERIOD(T_PERIOD), .DEAD(T_DEAD), .BLANK(T_BLANK)) i_buck_gate_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .trip_i      (trip_i),
    .oc_sense_i  (oc_sense_i),
    .hs_gate_n_o (hs_gate_n_o),
    .ls_gate_o   (ls_gate_o),
    .cyc_start_o (cyc_start_o),
    .oc_event_o  (oc_event_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R5 monitor: overlap and short gaps, seen at every falling edge
  int gap_run = 0;
  int overlaps = 0;
  int short_gaps = 0;
  always @(negedge clk) begin
    if (!hs_gate_n_o && ls_gate_o) overlaps++;
    if (hs_gate_n_o && !ls_gate_o) gap_run++;
    else begin
      if (gap_run != 0 && gap_run < T_DEAD) short_gaps++;
      gap_run = 0;
    end
  end

  // Runs one period starting at the falling edge where the tick is visible
  task automatic run_period(input string tag, input logic [1:0] nxt_mode,
                            input int trip_k, input int oc_k, input bit hold,
                            input bit glitch, input int exp_hs, input int exp_oc,
                            input int exp_first, input int exp_ls);
    int hs_cnt = 0;
    int oc_cnt = 0;
    int first  = 255;
    int ls_end = 0;
    int tick_bad = 0;
    logic [1:0] cur = mode_i;
    for (int k = 0; k < T_PERIOD; k++) begin
      if (cyc_start_o != (k == 0)) tick_bad++;
      if (!hs_gate_n_o) begin
        hs_cnt++;
        if (first == 255) first = k;
      end
      if (oc_event_o) oc_cnt++;
      if (k == T_PERIOD - 1) ls_end = int'(ls_gate_o);
      trip_i     = (k == trip_k);
      oc_sense_i = hold ? (k >= oc_k && k < T_PERIOD - 1) : (k == oc_k);
      if (k == T_PERIOD - 1)        mode_i = nxt_mode;
      else if (glitch && k >= 50 && k < 60) mode_i = 2'b00;
      else                          mode_i = cur;
      @(negedge clk);
    end
    chk({tag, " R2 tick only at offset 0"}, tick_bad, 0);
    chk({tag, " R6 high-side on clocks"}, hs_cnt, exp_hs);
    chk({tag, " R7 overcurrent events"}, oc_cnt, exp_oc);
    chk({tag, " R4 first on offset"}, first, exp_first);
    chk({tag, " R9 low side at last offset"}, ls_end, exp_ls);
  endtask

  initial begin
    int bad;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 reset hs_gate_n", int'(hs_gate_n_o), 1);
    chk("R1 reset ls_gate", int'(ls_gate_o), 0);
    chk("R1 reset cyc_start", int'(cyc_start_o), 0);
    chk("R1 reset oc_event", int'(oc_event_o), 0);
    rst = 1'b0;
    // R1/R2/R3: idle until the first tick, which lands PERIOD clocks later
    bad = 0;
    for (int n = 1; n <= T_PERIOD; n++) begin
      @(negedge clk);
      if (n < T_PERIOD && cyc_start_o) bad++;
      if (!hs_gate_n_o || ls_gate_o || oc_event_o) bad++;
      if (n == T_PERIOD) chk("R2 first tick after PERIOD clocks", int'(cyc_start_o), 1);
    end
    chk("R1 idle before first period", bad, 0);

    // Vector table, one period per row
    for (int i = 0; i < NV; i++) begin
      run_period($sformatf("row%0d", i),
                 (i < NV - 1) ? VEC[i+1].mode : 2'b10,
                 int'(VEC[i].trip_k), int'(VEC[i].oc_k), 1'b0, VEC[i].glitch,
                 int'(VEC[i].exp_hs), int'(VEC[i].exp_oc),
                 int'(VEC[i].exp_first), int'(VEC[i].exp_ls));
    end

    // R10: flag held high, each period retries and raises one event
    for (int c = 0; c < 3; c++) begin
      run_period($sformatf("R10 held sense period%0d", c), 2'b10,
                 255, 0, 1'b1, 1'b0, 10, 1, 4, 1);
    end
    oc_sense_i = 1'b0;

    // R8: plain periods reach the duty cap
    run_period("R8 duty cap", 2'b01, 255, 255, 1'b0, 1'b0, 189, 0, 4, 1);

    chk("R5 gate overlap clocks", overlaps, 0);
    chk("R5 short dead gaps", short_gaps, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule